// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

An eight-pin general-purpose I/O port on a small memory-mapped register bus with an 8-bit data path, a 12-bit byte address and single-cycle read and write strobes. Each pin has a direction bit and an output data bit. The pin inputs reach the read path through a two-flop synchronizer.

A data access uses address bits [9:2] as a per-pin select mask. A write changes only the selected pins. A read returns zero in every unselected position. Software can therefore set, clear or sample any group of pins in one bus cycle, with no read-modify-write sequence. A value is accepted into a pin's output latch only while that pin is an output. Software that prepares a pin for output must write its value again after it sets the direction bit.

Top module: `gpio_masked_port`

## Requirements
- R1: While rst_ni is low, gpio_oe_o, gpio_o and rdata_o are all zero, so every pin is an input with output data 0.
- R2: A write to byte address 0x400 loads wdata_i into the direction register, where bit n = 1 makes pin n an output. gpio_oe_o shows the new value from the clock edge that takes the write.
- R3: A read of address 0x400 returns the current direction register.
- R4: A write to the data window (addr_i[11:10] = 0, addr_i[1:0] = 0) updates the output bit of pin n only if addr_i[n+2] is 1. All other output bits keep their value.
- R5: A data write does not change the output bit of a pin whose direction bit is 0. That bit keeps its earlier value after the pin becomes an output.
- R6: A read of the data window returns 0 in bit n whenever addr_i[n+2] is 0.
- R7: In a selected bit of a data read, an output pin returns its driven value. An input pin returns gpio_i as sampled two clock edges before the read edge.
- R8: Any address outside the data window and 0x400 (including addresses with addr_i[1:0] not zero) reads as 0. A write to such an address changes neither gpio_o nor gpio_oe_o.
- R9: rdata_o updates on the clock edge that takes rd_i and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| rdata_o | output | 8 | Registered read data |
| gpio_i | input | 8 | Pin input levels |
| gpio_o | output | 8 | Pin output values |
| gpio_oe_o | output | 8 | Pin output enables |

## Verification
The bench writes all ones through the full mask while every pin is an input, then turns the pins into outputs. A design that latches data regardless of direction would then drive ones where zeros belong. Partial-mask writes and reads catch a design that ignores the mask, or one that decodes it from the wrong address bits: the unselected pins would move, or unselected read bits would leak through. Reads of mixed-direction pins shortly after gpio_i changes expose a wrong synchronizer depth or a read that returns the output latch for input pins. Misaligned and out-of-window addresses expose a decoder that aliases the direction register or the data window.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_e;
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output gpio_pkg::acc_e    kind_o,
  output logic [NPINS-1:0]  mask_o
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << (NPINS + 2);
  localparam int HI_W = ADDR_W - NPINS - 2;

  logic aligned, in_window;

  assign aligned   = (addr_i[1:0] == 2'b00);
  assign in_window = (addr_i[ADDR_W-1:NPINS+2] == HI_W'(0));
  assign mask_o    = addr_i[NPINS+1:2];

  always_comb begin
    if (aligned && in_window)  kind_o = gpio_pkg::ACC_DATA;
    else if (addr_i == DIR_ADDR) kind_o = gpio_pkg::ACC_DIR;
    else                       kind_o = gpio_pkg::ACC_NONE;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  gpio_pkg::acc_e   kind_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] data_o
);
  logic [NPINS-1:0] dir_q, data_q, upd;

  // a data bit moves only when selected by address and driven as output
  assign upd = mask_i & dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_i) begin
      if (kind_i == gpio_pkg::ACC_DIR)  dir_q  <= wdata_i;
      if (kind_i == gpio_pkg::ACC_DATA) data_q <= (data_q & ~upd) | (wdata_i & upd);
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  gpio_pkg::acc_e   kind_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] data_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] rdata_o
);
  logic [NPINS-1:0] level, rd_d, rd_q;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    assign level[n] = dir_i[n] ? data_i[n] : pin_i[n];
  end

  always_comb begin
    unique case (kind_i)
      gpio_pkg::ACC_DATA: rd_d = level & mask_i;
      gpio_pkg::ACC_DIR:  rd_d = dir_i;
      default:            rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (rd_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  gpio_i,
  output logic [NPINS-1:0]  gpio_o,
  output logic [NPINS-1:0]  gpio_oe_o
);
  gpio_pkg::acc_e   kind;
  logic [NPINS-1:0] mask, dir, data, pin_s;

  gpio_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .mask_o (mask)
  );

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpio_i),
    .q_o    (pin_s)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .kind_i  (kind),
    .mask_i  (mask),
    .wdata_i (wdata_i),
    .dir_o   (dir),
    .data_o  (data)
  );

  gpio_rdmux #(.NPINS(NPINS)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .kind_i  (kind),
    .mask_i  (mask),
    .dir_i   (dir),
    .data_i  (data),
    .pin_i   (pin_s),
    .rdata_o (rdata_o)
  );

  assign gpio_o    = data;
  assign gpio_oe_o = dir;
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [NPINS-1:0]  rdata_o,
  input logic [NPINS-1:0]  gpio_i,
  input logic [NPINS-1:0]  gpio_o,
  input logic [NPINS-1:0]  gpio_oe_o
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << (NPINS + 2);
  localparam int HI_W = ADDR_W - NPINS - 2;

  logic is_data, is_dir, is_none;
  logic [NPINS-1:0] sel;
  assign is_data = (addr_i[ADDR_W-1:NPINS+2] == HI_W'(0)) && (addr_i[1:0] == 2'b00);
  assign is_dir  = (addr_i == DIR_ADDR);
  assign is_none = !is_data && !is_dir;
  assign sel     = addr_i[NPINS+1:2];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (gpio_o == '0 && gpio_oe_o == '0 && rdata_o == '0)
        else $error("R1 reset state");
    end
  end

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_dir) |=> gpio_oe_o == $past(wdata_i));

  p_dir_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_dir) |=> rdata_o == $past(gpio_oe_o));

  p_unsel_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_data) |=> (gpio_o & ~$past(sel)) == ($past(gpio_o) & ~$past(sel)));

  p_input_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_data) |=> (gpio_o & ~$past(gpio_oe_o)) == ($past(gpio_o) & ~$past(gpio_oe_o)));

  p_read_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_data) |=> (rdata_o & ~$past(sel)) == '0);

  p_unmapped_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_none) |=> rdata_o == '0);

  p_unmapped_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_none) |=> ($stable(gpio_o) && $stable(gpio_oe_o)));

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind gpio_masked_port gpio_masked_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_masked_port.sv
`timescale 1ns/1ps
module sim_gpio_masked_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, pins_in = '0, pins_out, pins_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_masked_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .gpio_i(pins_in), .gpio_o(pins_out), .gpio_oe_o(pins_oe)
  );

  // behavioural reference model
  int m_dir, m_dat, m_rd;
  int hist[$];

  function automatic int region(input logic [11:0] a);
    if (a[1:0] == 0 && a[11:10] == 0) return 1;
    if (a == 12'h400) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_dat = 0; m_rd = 0;
      hist = '{0, 0};
    end else begin
      int msk, pinv, r;
      msk  = int'(addr[9:2]);
      pinv = hist[1];
      r    = region(addr);
      if (rd) begin
        if (r == 1) begin
          m_rd = 0;
          for (int n = 0; n < 8; n++)
            if (msk[n]) m_rd[n] = m_dir[n] ? m_dat[n] : pinv[n];
        end else if (r == 2) m_rd = m_dir;
        else m_rd = 0;
      end
      if (wr && r == 1) begin
        for (int n = 0; n < 8; n++)
          if (msk[n] && m_dir[n]) m_dat[n] = wdata[n];
      end
      if (wr && r == 2) m_dir = int'(wdata);
      hist.push_front(int'(pins_in));
      hist = hist[0:1];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R2 oe vs model", int'(pins_oe), m_dir);
      check("R4 out vs model", int'(pins_out), m_dat);
      check("R7 rdata vs model", int'(rdata), m_rd);
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pins_in = 8'hA5;
    repeat (3) @(negedge clk);
    check("R1 oe at reset", int'(pins_oe), 0);
    check("R1 out at reset", int'(pins_out), 0);
    check("R1 rdata at reset", int'(rdata), 0);
    rst_n = 1'b1;

    bus_wr(12'h3FC, 8'hFF);              // all pins inputs: dropped
    bus_wr(12'h400, 8'h0F);
    check("R2 oe after dir write", int'(pins_oe), 8'h0F);
    check("R5 input write not kept", int'(pins_out), 8'h00);
    bus_rd(12'h400);
    check("R3 dir readback", int'(rdata), 8'h0F);

    bus_wr(12'h014, 8'hFF);              // pins 0 and 2
    check("R4 masked write", int'(pins_out), 8'h05);
    bus_wr(12'h3FC, 8'hAA);
    check("R5 inputs untouched", int'(pins_out), 8'h0A);

    bus_rd(12'h3FC);
    check("R7 mixed read", int'(rdata), 8'hAA);
    bus_rd(12'h0C0);                     // pins 4,5
    check("R6 masked read", int'(rdata), 8'h20);
    bus_rd(12'h00C);                     // pins 0,1
    check("R6 masked out read", int'(rdata), 8'h02);

    @(negedge clk); pins_in = 8'h5A;
    bus_rd(12'h3C0);                     // one edge after change: old value
    check("R7 sync latency old", int'(rdata), 8'hA0);
    bus_rd(12'h3C0);
    check("R7 sync latency new", int'(rdata), 8'h50);

    repeat (3) @(negedge clk);
    check("R9 rdata held", int'(rdata), 8'h50);

    bus_wr(12'h800, 8'hFF);
    bus_wr(12'h404, 8'hFF);
    bus_wr(12'h3FD, 8'hFF);
    check("R8 unmapped write oe", int'(pins_oe), 8'h0F);
    check("R8 unmapped write out", int'(pins_out), 8'h0A);
    bus_rd(12'h404);
    check("R8 unmapped read", int'(rdata), 0);
    bus_rd(12'h3FE);
    check("R8 misaligned read", int'(rdata), 0);

    bus_wr(12'h400, 8'h00);
    bus_wr(12'h400, 8'hFF);
    check("R5 latch kept across input", int'(pins_out), 8'h0A);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      pins_in = r[31:24];
      unique case (r[1:0])
        2'd0: addr = {2'b00, r[9:2], 2'b00};
        2'd1: addr = 12'h400;
        2'd2: addr = r[21:10];
        default: addr = {2'b00, r[9:2], r[23:22]};
      endcase
      wdata = r[17:10];
      wr = r[2];
      rd = r[3];
    end
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule